// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the raster timing for a display pipe, driven by the pixel clock. Software programs four packed 32-bit timing words: horizontal span, horizontal sync, vertical span and vertical sync. The block runs a pixel counter and a line counter over the programmed frame. From them it drives display enable, horizontal sync and vertical sync, and it exposes the current pixel and line position. Horizontal sizes are counted in character clocks of eight pixels. The horizontal sync start is given in pixels. Vertical sizes are counted in lines.

The four timing words are taken in only at frame boundaries, so a frame never mixes two programmings. Each sync output has its own polarity bit. Three blanking inputs act at once, without waiting for a frame boundary: one silences display enable, and the other two park horizontal sync or vertical sync at its idle level. All pins are plain level signals. The block has no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `crtc_timing_gen`

## Requirements
- R1: While rst_n is low, de_o, hsync_o and vsync_o are 0 and pix_x_o and line_y_o are 0. The first clock edge after release samples the timing words, and the next cycle presents pixel 0 of line 0.
- R2: pix_x_o counts from 0 up to (HT+1)*8-1 and then returns to 0. HT is h_span_i[9:0].
- R3: line_y_o advances by one whenever pix_x_o wraps. It runs from 0 up to VT and then returns to 0. VT is v_span_i[15:0].
- R4: de_o is 1 exactly when pix_x_o < (HD+1)*8 and line_y_o < VD+1. HD is h_span_i[24:16] and VD is v_span_i[31:16].
- R5: The horizontal sync is active while HS <= pix_x_o < HS+8*HW. HS is h_sync_i[12:0] and HW is h_sync_i[21:16]. HW=0 behaves as HW=1.
- R6: The vertical sync is active while VS+1 <= line_y_o < VS+1+VW. VS is v_sync_i[11:0] and VW is v_sync_i[20:16]. VW=0 behaves as VW=1.
- R7: Bit 23 of h_sync_i inverts hsync_o, and bit 23 of v_sync_i inverts vsync_o. When the bit is set the sync is active low and idles high. When it is clear the sync is active high.
- R8: blank_de_i forces de_o to 0. blank_hs_i holds hsync_o at its idle level, and blank_vs_i holds vsync_o at its idle level. Each acts in the same cycle it is applied.
- R9: The timing words are sampled only at the edge where the counters return to pixel 0 of line 0, and at start-up. A change made mid-frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_span_i | input | 32 | Horizontal total [9:0] and display end [24:16], in character clocks minus one |
| h_sync_i | input | 32 | Horizontal sync start [12:0] in pixels, width [21:16] in character clocks, polarity [23] |
| v_span_i | input | 32 | Vertical total [15:0] and display end [31:16], in lines minus one |
| v_sync_i | input | 32 | Vertical sync start [11:0] as line minus one, width [20:16] in lines, polarity [23] |
| blank_de_i | input | 1 | Forces display enable low |
| blank_hs_i | input | 1 | Holds horizontal sync idle |
| blank_vs_i | input | 1 | Holds vertical sync idle |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| pix_x_o | output | 13 | Current pixel within the line |
| line_y_o | output | 16 | Current line within the frame |

## Verification
The counters and the sampled timing words are registered, and every output is decoded from them combinationally. Position, enable and sync results for a clock edge are therefore due in the cycle that edge opens. A blanking input changes its output in the same cycle, and a new timing word shows up only from the first pixel of the frame after the next wrap. The bench's reference model steps once per rising edge and queues the expected position and window flags. The monitor samples a quarter period after the edge, while inputs only move on falling edges. It folds in the blanking inputs present at that moment and compares.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CHAR_LOG = 3;
  localparam int HTOT_W   = 10;
  localparam int HDSP_W   = 9;
  localparam int HSS_W    = 13;
  localparam int HSW_W    = 6;
  localparam int VTOT_W   = 16;
  localparam int VDSP_W   = 16;
  localparam int VSS_W    = 12;
  localparam int VSW_W    = 5;
  localparam int FIELD_HI = 16;
  localparam int POL_BIT  = 23;

  localparam int X_W    = HTOT_W + CHAR_LOG;
  localparam int HWIN_W = X_W + 1;
  localparam int VWIN_W = VTOT_W + 2;

  typedef struct packed {
    logic [X_W-1:0]    h_last;
    logic [HWIN_W-1:0] h_disp_len;
    logic [HWIN_W-1:0] hs_start;
    logic [HWIN_W-1:0] hs_len;
    logic              hs_pol;
    logic [VTOT_W-1:0] v_last;
    logic [VWIN_W-1:0] v_disp_len;
    logic [VWIN_W-1:0] vs_start;
    logic [VWIN_W-1:0] vs_len;
    logic              vs_pol;
  } crtc_cfg_t;

  // Unpacks the four timing words into pixel/line window bounds.
  function automatic crtc_cfg_t crtc_decode(input logic [31:0] hspan,
                                            input logic [31:0] hsyn,
                                            input logic [31:0] vspan,
                                            input logic [31:0] vsyn);
    crtc_cfg_t        c;
    logic [HSW_W-1:0] hw;
    logic [VSW_W-1:0] vw;
    hw = hsyn[FIELD_HI +: HSW_W];
    if (hw == '0) hw = HSW_W'(1);
    vw = vsyn[FIELD_HI +: VSW_W];
    if (vw == '0) vw = VSW_W'(1);
    c.h_last     = {hspan[HTOT_W-1:0], {CHAR_LOG{1'b1}}};
    c.h_disp_len = (HWIN_W'(hspan[FIELD_HI +: HDSP_W]) + HWIN_W'(1)) << CHAR_LOG;
    c.hs_start   = HWIN_W'(hsyn[HSS_W-1:0]);
    c.hs_len     = HWIN_W'(hw) << CHAR_LOG;
    c.hs_pol     = hsyn[POL_BIT];
    c.v_last     = vspan[VTOT_W-1:0];
    c.v_disp_len = VWIN_W'(vspan[FIELD_HI +: VDSP_W]) + VWIN_W'(1);
    c.vs_start   = VWIN_W'(vsyn[VSS_W-1:0]) + VWIN_W'(1);
    c.vs_len     = VWIN_W'(vw);
    c.vs_pol     = vsyn[POL_BIT];
    return c;
  endfunction
endpackage

// File: rtl/crtc_cfg_shadow.sv
module crtc_cfg_shadow
  import crtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] h_span,
  input  logic [31:0] h_sync,
  input  logic [31:0] v_span,
  input  logic [31:0] v_sync,
  output crtc_cfg_t   cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= '0;
    else if (load) cfg <= crtc_decode(h_span, h_sync, v_span, v_sync);
  end
endmodule

// File: rtl/crtc_raster_cnt.sv
module crtc_raster_cnt
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [X_W-1:0]    h_last,
  input  logic [VTOT_W-1:0] v_last,
  output logic [X_W-1:0]    x,
  output logic [VTOT_W-1:0] y,
  output logic              run,
  output logic              load_cfg
);
  localparam logic [X_W-1:0]    X_ONE = X_W'(1);
  localparam logic [VTOT_W-1:0] Y_ONE = VTOT_W'(1);

  logic x_end, y_end;
  assign x_end    = (x == h_last);
  assign y_end    = (y == v_last);
  assign load_cfg = !run || (x_end && y_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      x   <= '0;
      y   <= '0;
    end else if (!run) begin
      run <= 1'b1;
    end else if (x_end) begin
      x <= '0;
      y <= y_end ? '0 : y + Y_ONE;
    end else begin
      x <= x + X_ONE;
    end
  end
endmodule

// File: rtl/crtc_window.sv
module crtc_window #(
  parameter int W = 8
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] len,
  output logic         hit
);
  logic [W:0] stop;
  assign stop = {1'b0, start} + {1'b0, len};
  assign hit  = (pos >= start) && ({1'b0, pos} < stop);
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       h_span_i,
  input  logic [31:0]       h_sync_i,
  input  logic [31:0]       v_span_i,
  input  logic [31:0]       v_sync_i,
  input  logic              blank_de_i,
  input  logic              blank_hs_i,
  input  logic              blank_vs_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [X_W-1:0]    pix_x_o,
  output logic [VTOT_W-1:0] line_y_o
);
  crtc_cfg_t         cfg;
  logic              run, load_cfg;
  logic [X_W-1:0]    x;
  logic [VTOT_W-1:0] y;
  logic              h_vis, v_vis, hs_act, vs_act;
  logic [HWIN_W-1:0] xw;
  logic [VWIN_W-1:0] yw;

  crtc_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load_cfg),
    .h_span(h_span_i), .h_sync(h_sync_i),
    .v_span(v_span_i), .v_sync(v_sync_i), .cfg(cfg)
  );

  crtc_raster_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .h_last(cfg.h_last), .v_last(cfg.v_last),
    .x(x), .y(y), .run(run), .load_cfg(load_cfg)
  );

  assign xw = HWIN_W'(x);
  assign yw = VWIN_W'(y);

  crtc_window #(.W(HWIN_W)) u_hvis (.pos(xw), .start('0), .len(cfg.h_disp_len), .hit(h_vis));
  crtc_window #(.W(VWIN_W)) u_vvis (.pos(yw), .start('0), .len(cfg.v_disp_len), .hit(v_vis));
  crtc_window #(.W(HWIN_W)) u_hsw  (.pos(xw), .start(cfg.hs_start), .len(cfg.hs_len), .hit(hs_act));
  crtc_window #(.W(VWIN_W)) u_vsw  (.pos(yw), .start(cfg.vs_start), .len(cfg.vs_len), .hit(vs_act));

  assign de_o     = run & h_vis & v_vis & ~blank_de_i;
  assign hsync_o  = (run & hs_act & ~blank_hs_i) ^ cfg.hs_pol;
  assign vsync_o  = (run & vs_act & ~blank_vs_i) ^ cfg.vs_pol;
  assign pix_x_o  = x;
  assign line_y_o = y;
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input crtc_cfg_t         cfg,
  input logic [X_W-1:0]    x,
  input logic [VTOT_W-1:0] y,
  input logic              de,
  input logic              hs,
  input logic              vs,
  input logic              b_de,
  input logic              b_hs,
  input logic              b_vs
);
  localparam logic [X_W-1:0]    X_ONE = X_W'(1);
  localparam logic [VTOT_W-1:0] Y_ONE = VTOT_W'(1);

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!de && !hs && !vs));

  a_r2_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && x != cfg.h_last) |=> (x == $past(x) + X_ONE));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && x == cfg.h_last && y != cfg.v_last) |=> (x == '0 && y == $past(y) + Y_ONE));

  a_r4_de_inside: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (HWIN_W'(x) < cfg.h_disp_len && VWIN_W'(y) < cfg.v_disp_len));

  a_r8_blank_de: assert property (@(posedge clk) disable iff (!rst_n)
    b_de |-> !de);

  a_r8_hs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && b_hs) |-> (hs == cfg.hs_pol));

  a_r8_vs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && b_vs) |-> (vs == cfg.vs_pol));

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (x != '0 || y != '0)) |-> $stable(cfg));
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cfg(cfg),
  .x(pix_x_o), .y(line_y_o), .de(de_o), .hs(hsync_o), .vs(vsync_o),
  .b_de(blank_de_i), .b_hs(blank_hs_i), .b_vs(blank_vs_i)
);

// File: tb/crtc_timing_gen_test.sv
module crtc_timing_gen_test;
  import crtc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] h_span = '0, h_sync = '0, v_span = '0, v_sync = '0;
  logic b_de = 1'b0, b_hs = 1'b0, b_vs = 1'b0;
  logic hs, vs, de;
  logic [X_W-1:0] px;
  logic [VTOT_W-1:0] ly;

  crtc_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .h_span_i(h_span), .h_sync_i(h_sync),
    .v_span_i(v_span), .v_sync_i(v_sync), .blank_de_i(b_de),
    .blank_hs_i(b_hs), .blank_vs_i(b_vs), .hsync_o(hs), .vsync_o(vs),
    .de_o(de), .pix_x_o(px), .line_y_o(ly)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  string phase = "R1";

  typedef struct {
    int x; int y; bit run; bit ha; bit va; bit hd; bit vd; bit hp; bit vp;
  } exp_t;
  exp_t sbq[$];

  // reference model state
  bit m_run = 0;
  int mx = 0, my = 0;
  int m_ht = 0, m_hd = 0, m_hs = 0, m_hw = 1, m_vt = 0, m_vd = 0, m_vs = 0, m_vw = 1;
  bit m_hp = 0, m_vp = 0;

  function automatic logic [31:0] pack_span(int tot, int dsp);
    return (32'(dsp) << 16) | 32'(tot);
  endfunction
  function automatic logic [31:0] pack_sync(int st, int w, bit pol);
    return 32'(st) | (32'(w) << 16) | (pol ? 32'h0080_0000 : 32'h0);
  endfunction

  task automatic model_load();
    m_ht = int'(h_span[9:0]);   m_hd = int'(h_span[24:16]);
    m_hs = int'(h_sync[12:0]);  m_hw = int'(h_sync[21:16]); m_hp = h_sync[23];
    m_vt = int'(v_span[15:0]);  m_vd = int'(v_span[31:16]);
    m_vs = int'(v_sync[11:0]);  m_vw = int'(v_sync[20:16]); m_vp = v_sync[23];
    if (m_hw == 0) m_hw = 1;
    if (m_vw == 0) m_vw = 1;
  endtask

  // driver side of the scoreboard: step the model and queue the expectation
  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      m_run = 0; mx = 0; my = 0;
      m_ht = 0; m_hd = 0; m_hs = 0; m_hw = 1; m_vt = 0; m_vd = 0; m_vs = 0; m_vw = 1;
      m_hp = 0; m_vp = 0;
    end else if (!m_run) begin
      model_load();
      m_run = 1;
    end else if (mx == (m_ht + 1) * 8 - 1) begin
      mx = 0;
      if (my == m_vt) begin
        my = 0;
        model_load();
      end else my = my + 1;
    end else mx = mx + 1;
    e.x = mx; e.y = my; e.run = m_run;
    e.hd = (mx < (m_hd + 1) * 8);
    e.vd = (my < m_vd + 1);
    e.ha = (mx >= m_hs) && (mx < m_hs + 8 * m_hw);
    e.va = (my >= m_vs + 1) && (my < m_vs + 1 + m_vw);
    e.hp = m_hp; e.vp = m_vp;
    sbq.push_back(e);
  end

  task automatic check(string req, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s (phase %s) t=%0t: actual=%0d expected=%0d", req, phase, $time, got, expv);
    end
  endtask

  // monitor: sample a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check("R2 pix_x", int'(px), e.x);
      check("R3 line_y", int'(ly), e.y);
      check("R4/R8 de", int'(de), int'(e.run && e.hd && e.vd && !b_de));
      check("R5/R7/R8 hsync", int'(hs), int'((e.run && e.ha && !b_hs) ^ e.hp));
      check("R6/R7/R8 vsync", int'(vs), int'((e.run && e.va && !b_vs) ^ e.vp));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, then start-up sampling of config A
    h_span = pack_span(3, 1); h_sync = pack_sync(18, 1, 0);
    v_span = pack_span(5, 2); v_sync = pack_sync(3, 1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R2_R3_R4";
    repeat (400) @(negedge clk);
    // R8: each blanking control alone
    phase = "R8";
    b_de = 1'b1; repeat (60) @(negedge clk); b_de = 1'b0;
    b_hs = 1'b1; repeat (200) @(negedge clk); b_hs = 1'b0;
    b_vs = 1'b1; repeat (200) @(negedge clk); b_vs = 1'b0;
    // R9: mid-frame write of config B (zero widths, inverted polarity)
    phase = "R9";
    repeat (37) @(negedge clk);
    h_span = pack_span(4, 2); h_sync = pack_sync(30, 0, 1);
    v_span = pack_span(4, 3); v_sync = pack_sync(1, 0, 1);
    repeat (300) @(negedge clk);
    // R7: inverted syncs idle high, also under blanking
    phase = "R7";
    b_hs = 1'b1; b_vs = 1'b1; repeat (120) @(negedge clk); b_hs = 1'b0; b_vs = 1'b0;
    repeat (200) @(negedge clk);
    // R5/R6: wider syncs at the start of line and frame
    phase = "R5_R6";
    h_span = pack_span(5, 3); h_sync = pack_sync(0, 2, 0);
    v_span = pack_span(7, 5); v_sync = pack_sync(0, 2, 1);
    repeat (1000) @(negedge clk);
    // R1: reset in mid-run
    phase = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    @(posedge clk); #6;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule